// File: doc/BRIEF.md
# Strobe-Directed Register Bank

This block is a bank of 32-bit registers behind an AHB-style pipelined slave port that has no read/write direction input. The byte-strobe field of each transfer decides its direction. A transfer with at least one strobe bit set is a write, and only the bytes it strobes change. A transfer with every strobe bit clear is a read, and it returns the whole word. Because the direction wire is dropped, the bus fabric has one less signal to route to every register island.

The slave samples the address phase when it is selected, the transfer type is NONSEQ or SEQ, and the bus is ready. It registers the word index and the strobes. In the next cycle, which is the data phase, it either merges the write data into the addressed register or drives that register onto the read bus. It never inserts wait states and it always answers OKAY.

Top module: `strb_dir_regbank`

## Requirements
- R1: After reset every register reads as 0x00000000, and the read bus carries 0x00000000.
- R2: An accepted transfer whose strobe field is 4'b0000 is a read. In the following cycle (its data phase) the read bus carries the full 32-bit content of the addressed register.
- R3: An accepted transfer whose strobe field is nonzero is a write. Strobe bit k selects byte k (bits 8k+7:8k). Only those bytes take the value on the write-data bus during the data phase. The other bytes keep their value.
- R4: A transfer presented while the select input is low changes no register and produces no read data.
- R5: Transfer type IDLE (2'b00) and BUSY (2'b01) are not accepted. NONSEQ (2'b10) and SEQ (2'b11) are accepted.
- R6: An address phase presented while the bus-ready input is low is not accepted.
- R7: The register index is address bits [IDX_W+1:2], with IDX_W = log2(NREG) (default NREG = 16). Address bits 1:0 have no effect.
- R8: A read accepted in the cycle right after a write's address phase, to the same register, returns the value that write produced.
- R9: The ready output is always high and the response output is always 0 (OKAY).
- R10: Outside the data phase of a read, the read bus carries 0x00000000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Slave select |
| addr_i | input | IDX_W+2 | Byte address |
| trans_i | input | 2 | Transfer type |
| ready_i | input | 1 | Bus ready (previous data phase completing) |
| strb_i | input | 4 | Byte strobes; nonzero means write |
| wdata_i | input | 32 | Write data, valid in the data phase |
| rdata_o | output | 32 | Read data |
| readyout_o | output | 1 | Slave ready, constant high |
| resp_o | output | 1 | Response, constant OKAY |

## Verification
The hardest case to reach is a read that lands in the cycle right after a write to the same register. In that case the data phase of the write and the address phase of the read overlap, and the returned word must already contain the merge. The stimulus forces this pairing in directed sequences, including partial strobes. It also leaves the random mix with only four address values in its index field, so back-to-back same-register pairs occur often. Rejected transfers (select low, IDLE or BUSY, ready low) are mixed into the random traffic. Their lack of effect is observed through later reads.

// File: rtl/strb_dir_pkg.sv
package strb_dir_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned STRB_W = DATA_W / 8;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } trans_e;

  function automatic logic is_active(input logic [1:0] tr);
    return (tr == TR_NONSEQ) || (tr == TR_SEQ);
  endfunction
endpackage

// File: rtl/strb_dir_aphase.sv
module strb_dir_aphase
  import strb_dir_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [1:0]        trans_i,
  input  logic              ready_i,
  input  logic [STRB_W-1:0] strb_i,
  output logic              wr_en_o,
  output logic              rd_en_o,
  output logic [IDX_W-1:0]  ph_idx_o,
  output logic [STRB_W-1:0] ph_strb_o
);
  logic              ph_vld_q, ph_vld_d;
  logic [IDX_W-1:0]  ph_idx_q, ph_idx_d;
  logic [STRB_W-1:0] ph_strb_q, ph_strb_d;
  logic              accept;
  logic              ph_en;

  assign accept = sel_i && ready_i && is_active(trans_i);
  assign ph_en  = ready_i;

  always_comb begin
    ph_vld_d  = accept;
    ph_idx_d  = ph_idx_q;
    ph_strb_d = ph_strb_q;
    if (accept) begin
      ph_idx_d  = idx_i;
      ph_strb_d = strb_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_vld_q  <= 1'b0;
      ph_idx_q  <= '0;
      ph_strb_q <= '0;
    end else if (ph_en) begin
      ph_vld_q  <= ph_vld_d;
      ph_idx_q  <= ph_idx_d;
      ph_strb_q <= ph_strb_d;
    end
  end

  assign wr_en_o   = ph_vld_q && ready_i && (ph_strb_q != '0);
  assign rd_en_o   = ph_vld_q && (ph_strb_q == '0);
  assign ph_idx_o  = ph_idx_q;
  assign ph_strb_o = ph_strb_q;
endmodule

// File: rtl/strb_dir_regfile.sv
module strb_dir_regfile
  import strb_dir_pkg::*;
#(
  parameter int unsigned NREG  = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en_i,
  input  logic [IDX_W-1:0]            wr_idx_i,
  input  logic [STRB_W-1:0]           wr_strb_i,
  input  logic [DATA_W-1:0]           wdata_i,
  output logic [NREG-1:0][DATA_W-1:0] regs_o
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic hit;
    assign hit = wr_en_i && (wr_idx_i == IDX_W'(r));
    for (genvar b = 0; b < STRB_W; b++) begin : g_byte
      logic       byte_en;
      logic [7:0] byte_q, byte_d;
      assign byte_en = hit && wr_strb_i[b];
      always_comb begin
        byte_d = byte_q;
        if (byte_en) byte_d = wdata_i[8*b +: 8];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       byte_q <= 8'h00;
        else if (byte_en) byte_q <= byte_d;
      end
      assign regs_o[r][8*b +: 8] = byte_q;
    end
  end
endmodule

// File: rtl/strb_dir_rdmux.sv
module strb_dir_rdmux
  import strb_dir_pkg::*;
#(
  parameter int unsigned NREG  = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic [NREG-1:0][DATA_W-1:0] regs_i,
  input  logic                        rd_en_i,
  input  logic [IDX_W-1:0]            rd_idx_i,
  output logic [DATA_W-1:0]           rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int r = 0; r < NREG; r++) begin
      if (rd_en_i && (rd_idx_i == IDX_W'(r))) rdata_o = regs_i[r];
    end
  end
endmodule

// File: rtl/strb_dir_regbank.sv
module strb_dir_regbank
  import strb_dir_pkg::*;
#(
  parameter int unsigned NREG   = 16,
  localparam int unsigned IDX_W  = (NREG > 1) ? $clog2(NREG) : 1,
  localparam int unsigned ADDR_W = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        trans_i,
  input  logic              ready_i,
  input  logic [3:0]        strb_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              readyout_o,
  output logic              resp_o
);
  logic                        wr_en, rd_en;
  logic [IDX_W-1:0]            ph_idx;
  logic [STRB_W-1:0]           ph_strb;
  logic [NREG-1:0][DATA_W-1:0] regs;
  logic                        unused_lsb;

  assign unused_lsb = ^addr_i[1:0];

  strb_dir_aphase #(.IDX_W(IDX_W)) u_aphase (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (sel_i),
    .idx_i     (addr_i[ADDR_W-1:2]),
    .trans_i   (trans_i),
    .ready_i   (ready_i),
    .strb_i    (strb_i),
    .wr_en_o   (wr_en),
    .rd_en_o   (rd_en),
    .ph_idx_o  (ph_idx),
    .ph_strb_o (ph_strb)
  );

  strb_dir_regfile #(.NREG(NREG), .IDX_W(IDX_W)) u_regfile (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_idx_i  (ph_idx),
    .wr_strb_i (ph_strb),
    .wdata_i   (wdata_i),
    .regs_o    (regs)
  );

  strb_dir_rdmux #(.NREG(NREG), .IDX_W(IDX_W)) u_rdmux (
    .regs_i   (regs),
    .rd_en_i  (rd_en),
    .rd_idx_i (ph_idx),
    .rdata_o  (rdata_o)
  );

  assign readyout_o = 1'b1;
  assign resp_o     = 1'b0;
endmodule

// File: rtl/strb_dir_chk.sv
module strb_dir_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [1:0]        trans_i,
  input logic              ready_i,
  input logic [3:0]        strb_i,
  input logic [31:0]       rdata_o,
  input logic              readyout_o,
  input logic              resp_o,
  input logic              wr_en
);
  logic unused_addr;
  assign unused_addr = ^addr_i;

  AST_ZERO_WAIT_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
    readyout_o && !resp_o); // R9

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ready_i) && !($past(sel_i) && $past(trans_i[1]) && ($past(strb_i) == 4'b0000)))
      |-> (rdata_o == 32'h0)); // R10

  AST_WRITE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(sel_i)); // R4

  AST_WRITE_NEEDS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(trans_i[1])); // R5

  AST_WRITE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(ready_i)); // R6

  AST_WRITE_NEEDS_STRB: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ($past(strb_i) != 4'b0000)); // R3
endmodule

bind strb_dir_regbank strb_dir_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sel_i      (sel_i),
  .addr_i     (addr_i),
  .trans_i    (trans_i),
  .ready_i    (ready_i),
  .strb_i     (strb_i),
  .rdata_o    (rdata_o),
  .readyout_o (readyout_o),
  .resp_o     (resp_o),
  .wr_en      (wr_en)
);

// File: tb/test_strb_dir_regbank.sv
module test_strb_dir_regbank;
  localparam int NREG = 16;
  localparam int AW   = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel_i;
  logic [AW-1:0] addr_i;
  logic [1:0]    trans_i;
  logic          ready_i;
  logic [3:0]    strb_i;
  logic [31:0]   wdata_i;
  logic [31:0]   rdata_o;
  logic          readyout_o;
  logic          resp_o;

  strb_dir_regbank #(.NREG(NREG)) i_strb_dir_regbank (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .addr_i(addr_i),
    .trans_i(trans_i), .ready_i(ready_i), .strb_i(strb_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .readyout_o(readyout_o),
    .resp_o(resp_o)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] model [NREG];
  logic        pend_v;
  logic [3:0]  pend_idx, last_wr_idx;
  logic [3:0]  pend_strb;
  logic        last_was_wr;
  bit          done = 0;

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                        input logic [3:0] st);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (st[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  function automatic bit accepted(input logic s, input logic [1:0] t, input logic rd);
    return s && rd && t[1];
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // One cycle: check the current data phase, commit model, present new address phase.
  task automatic cyc(input logic s, input logic [AW-1:0] a, input logic [1:0] t,
                     input logic rd, input logic [3:0] st, input logic [31:0] wd);
    logic [31:0] exp;
    string tag;
    exp = (pend_v && pend_strb == 4'b0) ? model[pend_idx] : 32'h0;
    if (pend_v && pend_strb == 4'b0)
      tag = (last_was_wr && last_wr_idx == pend_idx) ? "R8" : "R2";
    else
      tag = "R10";
    check(tag, rdata_o, exp);
    check("R9", {30'h0, readyout_o, resp_o}, {30'h0, 1'b1, 1'b0});
    last_was_wr = 1'b0;
    if (pend_v && pend_strb != 4'b0 && rd) begin
      model[pend_idx] = merge(model[pend_idx], wd, pend_strb);
      last_was_wr = 1'b1;
      last_wr_idx = pend_idx;
    end
    sel_i = s; addr_i = a; trans_i = t; ready_i = rd; strb_i = st; wdata_i = wd;
    if (rd) begin
      pend_v    = accepted(s, t, rd);
      pend_idx  = a[5:2];
      pend_strb = st;
    end
    @(posedge clk);
    #2.5;
  endtask

  task automatic idle();
    cyc(1'b0, '0, 2'b00, 1'b1, 4'h0, 32'h0);
  endtask

  task automatic rd_word(input logic [3:0] idx);
    cyc(1'b1, {idx, 2'b00}, 2'b10, 1'b1, 4'h0, 32'hDEAD_BEEF);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd1234);
    for (int i = 0; i < NREG; i++) model[i] = 32'h0;
    pend_v = 0; pend_idx = 0; pend_strb = 0; last_was_wr = 0; last_wr_idx = 0;
    rst_n = 0; sel_i = 0; addr_i = 0; trans_i = 0; ready_i = 1; strb_i = 0; wdata_i = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #2.5;
    check("R1", rdata_o, 32'h0);
    // R1: every register reads zero after reset
    for (int i = 0; i < NREG; i++) rd_word(4'(i));
    idle(); idle();
    // R3: full and partial byte writes, then read back
    cyc(1'b1, {4'd3, 2'b00}, 2'b10, 1'b1, 4'hF, 32'h0);
    cyc(1'b1, {4'd3, 2'b00}, 2'b10, 1'b1, 4'b0101, 32'h1122_3344);
    cyc(1'b1, {4'd3, 2'b00}, 2'b11, 1'b1, 4'h0, 32'hAABB_CCDD); // R8 read after write
    idle(); idle();
    // R7: address bits 1:0 do not change the register chosen
    cyc(1'b1, {4'd9, 2'b11}, 2'b10, 1'b1, 4'b1000, 32'h0);
    cyc(1'b0, '0, 2'b00, 1'b1, 4'h0, 32'h7700_0000);
    cyc(1'b1, {4'd9, 2'b01}, 2'b10, 1'b1, 4'h0, 32'h0);
    idle();
    // R4/R5/R6: rejected writes, then read target to show no change
    cyc(1'b0, {4'd5, 2'b00}, 2'b10, 1'b1, 4'hF, 32'h0);
    cyc(1'b1, {4'd5, 2'b00}, 2'b00, 1'b1, 4'hF, 32'h5555_5555);
    cyc(1'b1, {4'd5, 2'b00}, 2'b01, 1'b1, 4'hF, 32'h6666_6666);
    cyc(1'b1, {4'd5, 2'b00}, 2'b10, 1'b0, 4'hF, 32'h7777_7777);
    cyc(1'b1, {4'd5, 2'b00}, 2'b10, 1'b1, 4'h0, 32'h8888_8888);
    idle();
    // Random traffic, narrow index space to force same-register pairs
    for (int n = 0; n < 3000; n++) begin
      logic s, rd;
      logic [1:0] t;
      logic [3:0] st, ix;
      s  = ($urandom % 8) != 0;
      t  = 2'($urandom);
      rd = pend_v ? 1'b1 : (($urandom % 6) != 0);
      st = (($urandom % 2) == 0) ? 4'h0 : 4'($urandom);
      ix = {2'b00, 2'($urandom)};
      if (($urandom % 4) == 0) ix = 4'($urandom);
      cyc(s, {ix, 2'($urandom)}, t, rd, st, $urandom);
    end
    idle();
    for (int i = 0; i < NREG; i++) rd_word(4'(i));
    idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule